// File: doc/BRIEF.md
# Two-Wire Programming Port Register Readout

This block is the target end of a two-wire serial programming port. A host supplies a slow clock and shares one bidirectional data line with the target. Each transaction opens with a 4-bit control code, sent least significant bit first and sampled on rising host-clock edges. The host clock and data are brought into the system clock domain through two-flop synchronizers, and host-clock edges are detected there.

When the decoded code is the readout code, the block snapshots a 16-bit visibility word from its parallel load port. It then lets eight host clocks pass idle and drives the snapshot onto the data line, bit 0 first, changing the bit after each falling host-clock edge. The output enable stays on after the last bit. It drops on the first rising edge of the next transaction, and that same edge samples bit 0 of the next code. Any other code gives a single-cycle strobe with the code value, and fetch then carries on.

Top module: `twoWireReadout`

## Requirements
- R1: Control code bits are sampled on rising host-clock edges, least significant bit first, so the first bit sampled is bit 0 of the code value.
- R2: The code value 4'b0001 (bits sent 1,0,0,0) starts a readout and produces no strobe.
- R3: Every other code value produces exactly one system-clock cycle of `codeStrobe` with `codeValue` equal to the code, and fetching continues.
- R4: The output enable is low while a code is received (apart from the hold of R7) and during the 8 idle host clocks after the readout code.
- R5: After the 8 idle rising edges, the visibility word is driven LSb first, one bit per falling host-clock edge: bit k is valid before rising edge 13+k of the transaction, with the output enable high.
- R6: The visibility word is captured when the readout code is decoded; later changes on `visData` do not alter the bits shifted out.
- R7: After bit 15, the output enable stays high until the first rising host-clock edge of the next transaction, and is low after it.
- R8: A transaction that directly follows a readout decodes its code normally, with bit 0 sampled on the edge that releases the output.
- R9: `dataOut` is 0 whenever `dataOe` is 0.
- R10: Synchronous active-high reset gives code fetch, output enable low, data out low and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pinClk | input | 1 | Host programming clock (asynchronous, idles high) |
| pinDataIn | input | 1 | Data line as seen by the input buffer |
| visData | input | 16 | Parallel visibility word to read out |
| dataOut | output | 1 | Value driven onto the data line |
| dataOe | output | 1 | Output enable for the shared data line |
| codeStrobe | output | 1 | One-cycle pulse for decoded non-readout codes |
| codeValue | output | 4 | Code value qualified by `codeStrobe` |

## Verification
The bench uses the default parameters: 4-bit codes, a 16-bit word, 8 idle clocks and a two-stage synchronizer. The host clock runs with a half period of six system cycles. With 4-bit codes, every code value can be sent, so the strobe, its value and the bit order are checked for all sixteen codes. With a 16-bit word, a walking one covers each bit position. The readouts run back to back, so every transaction after the first also exercises the held output enable and its release.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [1:0] {
    ST_FETCH,
    ST_WAIT,
    ST_SHIFT
  } twrState_t;

  typedef struct packed {
    logic shiftCode;
    logic emitCode;
    logic loadVis;
    logic driveBit;
    logic releaseOe;
  } twrCtrl_t;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pinClk,
  input  logic pinData,
  output logic clkRise,
  output logic clkFall,
  output logic dataSync
);
  logic [STAGES-1:0] clkPipe;
  logic [STAGES-1:0] dataPipe;
  logic              clkPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clkPipe  <= '1;
      dataPipe <= '0;
      clkPrev  <= 1'b1;
    end else begin
      clkPipe  <= {clkPipe[STAGES-2:0], pinClk};
      dataPipe <= {dataPipe[STAGES-2:0], pinData};
      clkPrev  <= clkPipe[STAGES-1];
    end
  end

  assign clkRise  = clkPipe[STAGES-1] & ~clkPrev;
  assign clkFall  = ~clkPipe[STAGES-1] & clkPrev;
  assign dataSync = dataPipe[STAGES-1];
endmodule

// File: rtl/twr_ctrl.sv
module twr_ctrl
  import twr_pkg::*;
#(
  parameter int          CODE_BITS   = 4,
  parameter int          DATA_BITS   = 16,
  parameter int          IDLE_CYCLES = 8,
  parameter logic [CODE_BITS-1:0] READ_CODE = 4'b0001
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clkRise,
  input  logic                 clkFall,
  input  logic [CODE_BITS-1:0] nextCode,
  output twrCtrl_t             ctrl
);
  localparam int CNT_MAX0 = (DATA_BITS > IDLE_CYCLES) ? DATA_BITS : IDLE_CYCLES;
  localparam int CNT_MAX  = (CNT_MAX0 > CODE_BITS) ? CNT_MAX0 : CODE_BITS;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CODE_LAST = CNT_W'(CODE_BITS - 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(DATA_BITS);

  twrState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             codeDone;
  logic             isRead;

  assign codeDone = (cnt == CODE_LAST);
  assign isRead   = (nextCode == READ_CODE);

  always_comb begin
    ctrl = '0;
    unique case (state)
      ST_FETCH: begin
        if (clkRise) begin
          ctrl.shiftCode = 1'b1;
          ctrl.releaseOe = 1'b1;
          if (codeDone) begin
            ctrl.loadVis  = isRead;
            ctrl.emitCode = ~isRead;
          end
        end
      end
      ST_SHIFT: ctrl.driveBit = clkFall && (cnt < DATA_END);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_FETCH: if (clkRise) begin
          if (codeDone) begin
            cnt <= '0;
            if (isRead) state <= ST_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: if (clkRise) begin
          if (cnt == IDLE_LAST) begin
            cnt   <= '0;
            state <= ST_SHIFT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (clkFall && (cnt < DATA_END)) begin
            cnt <= cnt + 1'b1;
          end else if (clkRise && (cnt == DATA_END)) begin
            cnt   <= '0;
            state <= ST_FETCH;
          end
        end
        default: state <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/twr_datapath.sv
module twr_datapath
  import twr_pkg::*;
#(
  parameter int CODE_BITS = 4,
  parameter int DATA_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  twrCtrl_t             ctrl,
  input  logic                 dataSync,
  input  logic [DATA_BITS-1:0] visData,
  output logic [CODE_BITS-1:0] nextCode,
  output logic                 dataOut,
  output logic                 dataOe,
  output logic                 codeStrobe,
  output logic [CODE_BITS-1:0] codeValue
);
  logic [CODE_BITS-1:0] codeSr;
  logic [DATA_BITS-1:0] visReg;

  assign nextCode = {dataSync, codeSr[CODE_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      codeSr     <= '0;
      visReg     <= '0;
      dataOut    <= 1'b0;
      dataOe     <= 1'b0;
      codeStrobe <= 1'b0;
      codeValue  <= '0;
    end else begin
      if (ctrl.shiftCode) codeSr <= nextCode;
      if (ctrl.loadVis) begin
        visReg <= visData;
      end else if (ctrl.driveBit) begin
        visReg <= visReg >> 1;
      end
      if (ctrl.driveBit) begin
        dataOut <= visReg[0];
        dataOe  <= 1'b1;
      end else if (ctrl.releaseOe) begin
        dataOut <= 1'b0;
        dataOe  <= 1'b0;
      end
      codeStrobe <= ctrl.emitCode;
      if (ctrl.emitCode) codeValue <= nextCode;
    end
  end
endmodule

// File: rtl/twoWireReadout.sv
module twoWireReadout
  import twr_pkg::*;
#(
  parameter int CODE_BITS   = 4,
  parameter int DATA_BITS   = 16,
  parameter int IDLE_CYCLES = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [CODE_BITS-1:0] READ_CODE = 4'b0001
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pinClk,
  input  logic                 pinDataIn,
  input  logic [DATA_BITS-1:0] visData,
  output logic                 dataOut,
  output logic                 dataOe,
  output logic                 codeStrobe,
  output logic [CODE_BITS-1:0] codeValue
);
  logic                 clkRise;
  logic                 clkFall;
  logic                 dataSync;
  logic [CODE_BITS-1:0] nextCode;
  twrCtrl_t             ctrl;

  twr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pinClk(pinClk), .pinData(pinDataIn),
    .clkRise(clkRise), .clkFall(clkFall), .dataSync(dataSync)
  );

  twr_ctrl #(
    .CODE_BITS(CODE_BITS), .DATA_BITS(DATA_BITS),
    .IDLE_CYCLES(IDLE_CYCLES), .READ_CODE(READ_CODE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .clkRise(clkRise), .clkFall(clkFall),
    .nextCode(nextCode), .ctrl(ctrl)
  );

  twr_datapath #(.CODE_BITS(CODE_BITS), .DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .dataSync(dataSync),
    .visData(visData), .nextCode(nextCode), .dataOut(dataOut),
    .dataOe(dataOe), .codeStrobe(codeStrobe), .codeValue(codeValue)
  );
endmodule

// File: rtl/twoWireReadout_checker.sv
module twoWireReadout_checker #(
  parameter int CODE_BITS = 4,
  parameter logic [CODE_BITS-1:0] READ_CODE = 4'b0001
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 dataOut,
  input logic                 dataOe,
  input logic                 codeStrobe,
  input logic [CODE_BITS-1:0] codeValue
);
  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
    codeStrobe |=> !codeStrobe);

  assert_no_read_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    codeStrobe |-> (codeValue != READ_CODE));

  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    !dataOe |-> !dataOut);

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (!dataOe && !codeStrobe && !dataOut));

  assert_oe_not_with_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    codeStrobe |-> !dataOe);
endmodule

bind twoWireReadout twoWireReadout_checker #(
  .CODE_BITS(CODE_BITS), .READ_CODE(READ_CODE)
) u_chk (.*);

// File: tb/twoWireReadout_bench.sv
module twoWireReadout_bench;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pinClk = 1'b1;
  logic        pinDataIn = 1'b0;
  logic [15:0] visData = '0;
  logic        dataOut;
  logic        dataOe;
  logic        codeStrobe;
  logic [3:0]  codeValue;

  int checks = 0;
  int fails = 0;
  int strobeCount = 0;
  logic [3:0] lastCode = '0;

  always #4 clk = ~clk;

  twoWireReadout u_twoWireReadout (
    .clk(clk), .rst(rst), .pinClk(pinClk), .pinDataIn(pinDataIn),
    .visData(visData), .dataOut(dataOut), .dataOe(dataOe),
    .codeStrobe(codeStrobe), .codeValue(codeValue)
  );

  always @(posedge clk) begin
    if (!rst && codeStrobe) begin
      strobeCount = strobeCount + 1;
      lastCode = codeValue;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pinCycle(input logic d, output logic smp, output logic oeS);
    @(negedge clk);
    pinClk = 1'b0;
    pinDataIn = d;
    repeat (HALF) @(negedge clk);
    smp = dataOut;
    oeS = dataOe;
    pinClk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  // Sends a 4-bit code LSb first; reports oe seen before rise 1 and before rise 2.
  task automatic sendCode(input logic [3:0] c, output logic oe1, output logic oe2, output logic out2);
    logic smp, oeS;
    for (int b = 0; b < 4; b++) begin
      pinCycle(c[b], smp, oeS);
      if (b == 0) oe1 = oeS;
      if (b == 1) begin oe2 = oeS; out2 = smp; end
    end
  endtask

  task automatic doReadout(input logic [15:0] v, input logic changeVis, input logic expHold, input string req);
    logic smp, oeS, oe1, oe2, out2;
    logic [15:0] word;
    logic earlyOe, lateOff;
    int sBefore;
    earlyOe = 1'b0;
    lateOff = 1'b0;
    word = '0;
    visData = v;
    sBefore = strobeCount;
    sendCode(4'b0001, oe1, oe2, out2);
    if (oe2) earlyOe = 1'b1;
    check("R7 oe held before first rise", 32'(oe1), 32'(expHold));
    for (int k = 5; k <= 12; k++) begin
      pinCycle(1'b0, smp, oeS);
      if (oeS) earlyOe = 1'b1;
      if (k == 5 && changeVis) visData = ~v;
    end
    for (int k = 0; k < 16; k++) begin
      pinCycle(1'b0, smp, oeS);
      word[k] = smp;
      if (!oeS) lateOff = 1'b1;
    end
    check("R4 oe low during code and idle", 32'(earlyOe), 32'h0);
    check("R5 oe high during shift", 32'(lateOff), 32'h0);
    check(req, 32'(word), 32'(v));
    check("R2 readout gives no strobe", 32'(strobeCount - sBefore), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic oe1, oe2, out2;
    logic [15:0] pats [4];
    int sBefore;
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3; pats[3] = 16'h8001;

    repeat (5) @(negedge clk);
    check("R10 reset oe", 32'(dataOe), 32'h0);
    check("R10 reset strobe", 32'(codeStrobe), 32'h0);
    check("R10 reset dataOut", 32'(dataOut), 32'h0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1, R3: all non-readout codes, LSb first
    for (int c = 0; c < 16; c++) begin
      if (c == 1) continue;
      sBefore = strobeCount;
      sendCode(4'(c), oe1, oe2, out2);
      repeat (4) @(negedge clk);
      check("R3 one strobe per code", 32'(strobeCount - sBefore), 32'h1);
      check("R1 code value LSb first", 32'(lastCode), 32'(c));
      check("R4 oe low on plain code", 32'(oe1 | oe2), 32'h0);
    end

    // R5: walking one through every bit; back to back exercises R7 hold
    for (int i = 0; i < 16; i++)
      doReadout(16'(1) << i, 1'b0, (i != 0), "R5 walking one readout");
    for (int p = 0; p < 4; p++)
      doReadout(pats[p], 1'b0, 1'b1, "R5 pattern readout");

    // R6: visData changes after decode
    doReadout(16'h3C96, 1'b1, 1'b1, "R6 captured word readout");

    // R7, R8, R9: code after a readout
    sBefore = strobeCount;
    sendCode(4'h9, oe1, oe2, out2);
    repeat (4) @(negedge clk);
    check("R7 oe held until first rise", 32'(oe1), 32'h1);
    check("R7 oe released after first rise", 32'(oe2), 32'h0);
    check("R9 dataOut low when released", 32'(out2), 32'h0);
    check("R8 strobe after readout", 32'(strobeCount - sBefore), 32'h1);
    check("R8 code after readout", 32'(lastCode), 32'h9);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule